// File: doc/BRIEF.md
# Congestion-Aware Least-Recently-Served Output Arbiter

This block picks which of N input buffers may drive one output port of a router crossbar in the next cycle. Each requester raises a request line and reports a two-bit congestion level for its source buffer. The level runs from 0, an empty or freely draining buffer, to 3, a buffer whose flits have stopped moving. A single channel-available input gates every request. When the output channel cannot take a flit, nothing is granted.

Without the congestion override, the arbiter serves requesters in least-recently-served order. It keeps a triangular table of pairwise precedence bits. Only the bits above the diagonal are stored, and each mirrored bit is read as their complement. When the override is on, the congestion level is compared first, so a more congested buffer beats a less congested one. The precedence table settles a tie only between equal levels. The one-hot grant is registered, which gives a single arbitration stage. The precedence table is rewritten only in a cycle that produces a grant.

Top module: `fluid_matrix_arb`

## Requirements
- R1: After reset the grant output is all zero, and the starting precedence lets a lower index beat any higher index.
- R2: While `chan_avail` is low, the grant registered at the next edge is all zero, whatever the requests are.
- R3: The grant is at most one-hot. A one-hot grant follows every cycle that has at least one request with `chan_avail` high, and a zero grant follows every cycle that has none.
- R4: The grant is registered. It reflects the request, level and mode inputs of the cycle before, and it does not change until the next rising clock edge.
- R5: A grant bit is set only if that requester's request line was high in the cycle that produced it.
- R6: A granted requester becomes the lowest priority of all, and the other requesters keep their relative order.
- R7: With `prio_en` high, an active requester with a numerically larger level in `fluid_level[2i+1:2i]` beats one with a smaller level. A larger level means a more congested buffer.
- R8: With `prio_en` high, requesters of equal level are ordered by least-recently-served precedence.
- R9: With `prio_en` low, the level inputs have no effect on the grant.
- R10: A cycle that produces no grant, whether from no requests or from `chan_avail` low, leaves the precedence order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Request line per input buffer |
| chan_avail | input | 1 | Output channel can accept a flit this cycle |
| prio_en | input | 1 | Enables the congestion-level override |
| fluid_level | input | N*2 | Congestion level per requester; level i sits at bits [2i+1:2i], 0 most fluid, 3 least fluid |
| grant | output | N | Registered one-hot grant |

## Verification
The first pattern raises all five requests again and again. Each grant in the run shows that the winner moves to the back, which separates least-recently-served order from fixed index priority. Sparse requests against a rotated order show whether the rule compares only the active requesters. A cycle with the channel unavailable, followed by a partial request, shows that an ungranted cycle neither grants nor rotates the order. Level patterns tried with the override on and then off separate the congestion-first rule from the precedence tie-break, and show that the levels are ignored when the mode is off.

// File: rtl/fma_pkg.sv
package fma_pkg;

  // Position of pair (i,j), i<j, in the packed upper-triangle vector.
  function automatic int tri_idx(input int n, input int i, input int j);
    return i * n - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

  function automatic int tri_size(input int n);
    return (n * (n - 1)) / 2;
  endfunction

endpackage

// File: rtl/fma_order_state.sv
module fma_order_state
  import fma_pkg::*;
#(
  parameter int N = 5,
  localparam int P = tri_size(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [N-1:0] win,
  output logic [P-1:0] upper
);

  logic [P-1:0] upper_q;
  logic [P-1:0] upper_d;

  // Next state: the winner loses to everyone, and everyone else beats it.
  always_comb begin
    upper_d = upper_q;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (win[i]) begin
          upper_d[tri_idx(N, i, j)] = 1'b0;
        end else if (win[j]) begin
          upper_d[tri_idx(N, i, j)] = 1'b1;
        end
      end
    end
  end

  // All ones: lower index beats higher index, an acyclic start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '1;
    end else if (upd_en) begin
      upper_q <= upper_d;
    end
  end

  assign upper = upper_q;

  AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(upper_q)) else $error("order changed without grant"); // R10

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = gi + 1; gj < N; gj++) begin : g_col
      AST_WINNER_DEMOTED: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && win[gi]) |=> !upper_q[tri_idx(N, gi, gj)])
        else $error("winner not demoted"); // R6
      AST_LOSER_PROMOTED: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && win[gj]) |=> upper_q[tri_idx(N, gi, gj)])
        else $error("loser not promoted"); // R6
    end
  end

endmodule

// File: rtl/fma_pick.sv
module fma_pick
  import fma_pkg::*;
#(
  parameter int N  = 5,
  parameter int LW = 2,
  localparam int P = tri_size(N)
) (
  input  logic [N-1:0]    active,
  input  logic [N*LW-1:0] level,
  input  logic            prio_en,
  input  logic [P-1:0]    upper,
  output logic [N-1:0]    win
);

  logic [LW-1:0] lvl [N];
  logic [N-1:0]  beats [N]; // beats[j][i]: requester j takes precedence over i

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign lvl[g] = level[g*LW +: LW];
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      beats[j] = '0;
      for (int i = 0; i < N; i++) begin
        if (i != j) begin
          if (prio_en && (lvl[j] != lvl[i])) begin
            beats[j][i] = lvl[j] > lvl[i];
          end else if (j < i) begin
            beats[j][i] = upper[tri_idx(N, j, i)];
          end else begin
            beats[j][i] = ~upper[tri_idx(N, i, j)];
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      win[i] = active[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && active[j] && beats[j][i]) begin
          win[i] = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/fluid_matrix_arb.sv
module fluid_matrix_arb
  import fma_pkg::*;
#(
  parameter int N  = 5,
  parameter int LW = 2,
  localparam int P = tri_size(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic            chan_avail,
  input  logic            prio_en,
  input  logic [N*LW-1:0] fluid_level,
  output logic [N-1:0]    grant
);

  logic [N-1:0] active;
  logic [N-1:0] win;
  logic [P-1:0] upper;
  logic         any_win;
  logic [N-1:0] grant_q;
  logic [N-1:0] grant_d;

  assign active  = req & {N{chan_avail}};
  assign any_win = |win;
  assign grant_d = win;

  fma_pick #(.N(N), .LW(LW)) u_pick (
    .active  (active),
    .level   (fluid_level),
    .prio_en (prio_en),
    .upper   (upper),
    .win     (win)
  );

  fma_order_state #(.N(N)) u_order (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (any_win),
    .win    (win),
    .upper  (upper)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
    end else begin
      grant_q <= grant_d;
    end
  end

  assign grant = grant_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q)) else $error("grant not one-hot"); // R3
  AST_REQ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (|active) |=> (grant_q != '0)) else $error("request left unserved"); // R3
  AST_CHAN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_avail |=> (grant_q == '0)) else $error("grant while channel busy"); // R2
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0) |-> ((grant_q & ~$past(req)) == '0))
    else $error("grant without request"); // R5

  for (genvar gi = 0; gi < N; gi++) begin : g_lvl_a
    for (genvar gj = 0; gj < N; gj++) begin : g_lvl_b
      if (gi != gj) begin : g_pair
        AST_CONGESTED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
          (prio_en && active[gi] && active[gj] &&
           (fluid_level[gi*LW +: LW] > fluid_level[gj*LW +: LW])) |=> !grant_q[gj])
          else $error("less congested requester won"); // R7
      end
    end
  end

endmodule

// File: tb/tb_fluid_matrix_arb.sv
module tb_fluid_matrix_arb;

  localparam int N  = 5;
  localparam int LW = 2;

  typedef struct packed {
    logic [N-1:0]    req;
    logic            avail;
    logic            prio;
    logic [N*LW-1:0] lvl;
    logic [N-1:0]    exp;
  } vec_t;

  // Expected grants follow a served-last order model starting at 0,1,2,3,4.
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'b11111, 1'b1, 1'b0, 10'h000, 5'b00001}, // R1 reset order, 0 wins
    '{5'b11111, 1'b1, 1'b0, 10'h000, 5'b00010}, // R6 0 moved back
    '{5'b10001, 1'b1, 1'b0, 10'h000, 5'b10000}, // R6 4 now ahead of 0
    '{5'b11111, 1'b0, 1'b0, 10'h000, 5'b00000}, // R2 channel busy
    '{5'b00011, 1'b1, 1'b0, 10'h000, 5'b00001}, // R10 order kept
    '{5'b11111, 1'b1, 1'b1, 10'h300, 5'b10000}, // R7 level 3 wins
    '{5'b00110, 1'b1, 1'b1, 10'h018, 5'b00010}, // R7 level 2 beats level 1
    '{5'b11111, 1'b1, 1'b1, 10'h2AA, 5'b00100}, // R8 tie, order decides
    '{5'b10011, 1'b1, 1'b1, 10'h1F5, 5'b00001}, // R8 idle high levels ignored
    '{5'b11111, 1'b1, 1'b0, 10'h00C, 5'b01000}, // R9 levels ignored
    '{5'b00000, 1'b1, 1'b0, 10'h000, 5'b00000}, // R3 no request
    '{5'b01111, 1'b1, 1'b0, 10'h000, 5'b00010}  // R10 order kept after idle
  };

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    req;
  logic            chan_avail;
  logic            prio_en;
  logic [N*LW-1:0] fluid_level;
  logic [N-1:0]    grant;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  fluid_matrix_arb #(.N(N), .LW(LW)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .chan_avail  (chan_avail),
    .prio_en     (prio_en),
    .fluid_level (fluid_level),
    .grant       (grant)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string rq, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] r, input logic a, input logic p,
                       input logic [N*LW-1:0] l);
    req = r; chan_avail = a; prio_en = p; fluid_level = l;
  endtask

  initial begin
    drive('0, 1'b1, 1'b0, '0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset grant", grant, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].req, VECS[k].avail, VECS[k].prio, VECS[k].lvl);
      @(negedge clk);
      check($sformatf("vector %0d", k), grant, VECS[k].exp);
    end

    // R4: no change before the edge, new grant after it
    drive(5'b00100, 1'b1, 1'b0, '0);
    #1;
    check("R4 held before edge", grant, 5'b00010);
    @(negedge clk);
    check("R4 updated after edge", grant, 5'b00100);

    // R5: only the lone requester can win
    drive(5'b01000, 1'b1, 1'b1, 10'h3FF);
    @(negedge clk);
    check("R5 lone requester", grant, 5'b01000);

    // R1: reset restores index order mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 grant cleared", grant, '0);
    rst_n = 1'b1;
    drive(5'b11110, 1'b1, 1'b0, '0);
    @(negedge clk);
    check("R1 lowest index wins", grant, 5'b00010);
    drive('0, 1'b1, 1'b0, '0);
    @(negedge clk);
    check("R3 idle gives zero", grant, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule